// File: doc/BRIEF.md
# Stallable Three-Stage Register Pipeline

This block is a three-stage chain of edge-triggered registers with backpressure. The first stage is a counter that emits a rising sequence 1, 2, 3, and so on. The second stage is a plain hold register that passes the counter value forward. The final stage watches its input register, which is the middle register. When that register holds a chosen trigger value, the final stage stalls for good.

The stall is decoded combinationally from the register the final stage examines. It therefore reaches every upstream enable before the next clock edge. The trigger value stays frozen in the middle register, and the next sequence value never overwrites it. If the stall were registered, it would arrive one edge late, and the value after the trigger would slip past. The ready signal to each stage is the inverse of the stall, passed back through the chain. A synchronous reset is the only way out of a stall.

Top module: `stall_pipe3`

## Requirements
- R1: While `rst` is high at a rising edge, every stage register (`src_data`, `mid_data`, `fin_data`) becomes 0 after that edge, `fin_stall` is 0, and both ready outputs are 1.
- R2: While `rdy_to_src` is 1, the source register increases by exactly 1 per edge (modulo 2^W). Its first value after reset release is 1.
- R3: While `rdy_to_mid` is 1, the middle register loads the value that the source register held before the edge.
- R4: While `fin_stall` is 0, the final output register loads the value that the middle register held before the edge.
- R5: `fin_stall` is 1 in exactly those cycles in which `mid_data` equals the parameter `TRIG` (default 2). It rises in the same cycle that the trigger value lands in `mid_data`, with no added edge.
- R6: While `fin_stall` is 1, none of the three registers changes and the stall stays high. The middle register never moves from `TRIG` to another value except through reset. With defaults, `src_data` stays 3, `mid_data` stays 2 and `fin_data` stays 1.
- R7: `rdy_to_mid` equals the inverse of `fin_stall`, and `rdy_to_src` equals `rdy_to_mid`.
- R8: A reset applied while stalled clears the stall, and the sequence restarts from 1 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_data | output | W | Source counter register |
| mid_data | output | W | Middle register; the input register the final stage examines |
| fin_data | output | W | Final stage output register |
| fin_stall | output | 1 | Final stage stall, combinational from `mid_data` |
| rdy_to_mid | output | 1 | Ready from the final stage to the middle stage |
| rdy_to_src | output | 1 | Ready from the middle stage to the source |

## Verification
The in-module assertions check the following on every cycle:
- each enabled register takes its upstream value or increments by one;
- each disabled register stays stable;
- the stall, once raised, persists;
- reset clears everything.

Only the bench scenarios can show the timing of the whole sequence. In particular, the stall rises in the very cycle the trigger lands, and the value after the trigger never reaches the middle register. The bench also shows a restart through reset during a stall.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  parameter int unsigned DEF_W    = 32;
  parameter int unsigned DEF_TRIG = 2;

  // Next sequence value, computed wide; callers truncate to their width.
  function automatic logic [63:0] seq_next(input logic [63:0] v);
    return v + 64'd1;
  endfunction

  // Trigger match used by the final stage.
  function automatic logic hit_trigger(input logic [63:0] v, input logic [63:0] t);
    return v == t;
  endfunction
endpackage

// File: rtl/pipe_source.sv
module pipe_source #(
  parameter int unsigned W = pipe_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ready_in,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;
  logic         advance;

  assign advance = ready_in;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (advance) cnt_q <= W'(pipe_pkg::seq_next(64'(cnt_q)));
  end

  assign count = cnt_q;

  AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
    advance |=> (cnt_q - $past(cnt_q)) == W'(1)); // R2
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/pipe_hold_reg.sv
module pipe_hold_reg #(
  parameter int unsigned W = pipe_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)       q_r <= '0;
    else if (load) q_r <= d;
  end

  assign q = q_r;

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> q_r == $past(d)); // R3
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q_r)); // R6
endmodule

// File: rtl/pipe_final.sv
module pipe_final #(
  parameter int unsigned W    = pipe_pkg::DEF_W,
  parameter int unsigned TRIG = pipe_pkg::DEF_TRIG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_reg,
  output logic         stall,
  output logic         ready_up,
  output logic [W-1:0] out_q
);
  logic         busy;
  logic [W-1:0] out_r;

  // Decoded from the register contents, so upstream sees it before the next edge.
  assign busy     = pipe_pkg::hit_trigger(64'(in_reg), 64'(W'(TRIG)));
  assign stall    = busy;
  assign ready_up = !busy;

  always_ff @(posedge clk) begin
    if (rst)        out_r <= '0;
    else if (!busy) out_r <= in_reg;
  end

  assign out_q = out_r;

  AST_FIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> out_r == $past(in_reg)); // R4
  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy); // R6
  AST_FIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(out_r)); // R6
endmodule

// File: rtl/stall_pipe3.sv
module stall_pipe3 #(
  parameter int unsigned W    = pipe_pkg::DEF_W,
  parameter int unsigned TRIG = pipe_pkg::DEF_TRIG
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] src_data,
  output logic [W-1:0] mid_data,
  output logic [W-1:0] fin_data,
  output logic         fin_stall,
  output logic         rdy_to_mid,
  output logic         rdy_to_src
);
  logic [W-1:0] src_w, mid_w, fin_w;
  logic         stall_w, rdy_fin_w, rdy_mid_w;

  pipe_source #(.W(W)) u_src (
    .clk(clk), .rst(rst), .ready_in(rdy_mid_w), .count(src_w)
  );

  pipe_hold_reg #(.W(W)) u_mid (
    .clk(clk), .rst(rst), .load(rdy_fin_w), .d(src_w), .q(mid_w)
  );

  pipe_final #(.W(W), .TRIG(TRIG)) u_fin (
    .clk(clk), .rst(rst), .in_reg(mid_w), .stall(stall_w),
    .ready_up(rdy_fin_w), .out_q(fin_w)
  );

  // The middle stage has no stall of its own; it forwards the downstream ready.
  assign rdy_mid_w  = rdy_fin_w;

  assign src_data   = src_w;
  assign mid_data   = mid_w;
  assign fin_data   = fin_w;
  assign fin_stall  = stall_w;
  assign rdy_to_mid = rdy_fin_w;
  assign rdy_to_src = rdy_mid_w;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (src_w == '0 && mid_w == '0 && fin_w == '0)); // R1
  AST_TRIG_KEPT: assert property (@(posedge clk) disable iff (rst)
    (mid_w == W'(TRIG)) |=> (mid_w == W'(TRIG))); // R6
  AST_READY_STALL: assert property (@(posedge clk) disable iff (rst)
    rdy_to_mid != fin_stall); // R7
endmodule

// File: tb/test_stall_pipe3.sv
module test_stall_pipe3;
  localparam int unsigned W    = 32;
  localparam int unsigned TRIG = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] src_data, mid_data, fin_data;
  logic         fin_stall, rdy_to_mid, rdy_to_src;
  int           n_tests = 0;
  int           n_fail  = 0;
  bit           done    = 1'b0;

  always #10 clk = ~clk;

  stall_pipe3 #(.W(W), .TRIG(TRIG)) i_stall_pipe3 (
    .clk(clk), .rst(rst), .src_data(src_data), .mid_data(mid_data),
    .fin_data(fin_data), .fin_stall(fin_stall),
    .rdy_to_mid(rdy_to_mid), .rdy_to_src(rdy_to_src)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint lo(input longint a, input longint b);
    return (a < b) ? a : b;
  endfunction

  function automatic longint hi(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

  task automatic check_reset_state();
    check("R1 src", src_data, 0);
    check("R1 mid", mid_data, 0);
    check("R1 fin", fin_data, 0);
    check("R1 stall", fin_stall, 0);
    check("R1 rdy_mid", rdy_to_mid, 1);
    check("R1 rdy_src", rdy_to_src, 1);
  endtask

  // k = edges since reset release; expected values follow from the requirements.
  task automatic run_and_check(input int edges);
    for (int k = 1; k <= edges; k++) begin
      longint e_src, e_mid, e_fin;
      bit     e_stall;
      @(posedge clk);
      @(negedge clk);
      e_src   = lo(k, TRIG + 1);            // R2, frozen by R6
      e_mid   = hi(0, lo(k - 1, TRIG));     // R3
      e_fin   = hi(0, lo(k - 2, TRIG - 1)); // R4
      e_stall = (e_mid == TRIG);            // R5
      check("R2 src", src_data, e_src);
      check("R3 mid", mid_data, e_mid);
      check("R4 fin", fin_data, e_fin);
      check("R5 stall", fin_stall, e_stall);
      check("R7 rdy_mid", rdy_to_mid, !e_stall);
      check("R7 rdy_src", rdy_to_src, rdy_to_mid);
      check("R6 mid never past trigger", (mid_data <= TRIG), 1);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    run_and_check(50);
    // Reset while stalled, then restart (R8)
    check("R8 stalled before reset", fin_stall, 1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state();
    check("R8 stall cleared", fin_stall, 0);
    rst = 1'b0;
    run_and_check(8);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule